// File: doc/BRIEF.md
# Inter-processor and timer interrupt unit

This unit keeps two pending vectors, one bit per processor: an inter-processor interrupt (IPI) vector and an interval-timer vector. Each IPI bit drives that processor's level-3 interrupt line and each timer bit drives its level-2 line. Software posts and retires these bits through a register port. A multi-function control register packs an IPI request nibble, an IPI clear nibble and a timer clear nibble into one write. Three dedicated registers give direct access to the two vectors. A one-cycle tick input from an external interval timer marks the timer interrupt pending for every processor.

The register port is a request/response stream. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Exactly one response follows in the next cycle on `rsp_valid`. The response stays frozen while `rsp_ready` is low, and `req_ready` stays low until the response is taken, so at most one response is ever outstanding. A response may carry an error flag, for an unsupported write, or a warning flag, for a redundant post or clear. Neither flag stalls the port.

Register select `req_addr`: 0 = control, 1 = IPI pending, 2 = timer pending, 3 = IPI request.

Top module: `cpu_irq_hub`

## Requirements
- R1: A control write (addr 0) with bit 12+n set posts an IPI to processor n. The output `ipi_irq[n]` equals IPI-pending bit n.
- R2: A control write clears IPI-pending bit n when bit 8+n is set, and clears timer-pending bit n when bit 4+n is set.
- R3: Requesting an IPI for a processor that already has one pending leaves that bit unchanged and sets `rsp_warn`. Other processors in the same request are still posted.
- R4: Clearing an IPI for a processor with none pending leaves the vector unchanged and sets `rsp_warn`.
- R5: A high `tick` sets every timer-pending bit at the next edge, and `tmr_irq[n]` equals timer-pending bit n. When a tick and a timer clear hit the same processor in the same cycle, the bit stays set.
- R6: When one control write both requests and clears the IPI of the same processor, the clear is applied first and the request second. The bit ends up set, and no warning is raised if the bit was already pending.
- R7: Writing addr 1 clears the written IPI bits. Writing addr 2 clears the written timer bits. Writing addr 3 posts the written IPI bits (data bits [3:0], one per processor). Reading addr 1 or addr 2 returns the respective vector in bits [3:0]. Reading addr 3 returns 0.
- R8: A write to addr 1 or addr 3 whose processor vector is all zero sets `rsp_err` and changes nothing.
- R9: A control write with none of bit 28, bits [15:12], [11:8] or [7:4] set sets `rsp_err`. A control write with only bit 28 set is accepted with no error and no effect.
- R10: A control read returns the IPI vector in bits [11:8], the timer vector in bits [7:4] and `req_cpu` in bits [1:0]. All other bits are zero.
- R11: Each accepted request yields exactly one response in the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response is held stable, `req_ready` is low and no request is taken.
- R12: After reset both vectors are zero, all interrupt outputs are low and no response is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Interval-timer tick, marks timer interrupt pending for all processors |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register select |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 2 | ID of the requesting processor |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| rsp_err | output | 1 | Request was unsupported and had no effect |
| rsp_warn | output | 1 | Request contained a redundant post or clear |
| ipi_irq | output | NCPU | Level-3 interrupt per processor |
| tmr_irq | output | NCPU | Level-2 interrupt per processor |

## Verification
The bench targets the orderings that decide a bit's final value. A request and a clear of the same IPI in one write must leave the bit set; a design that lets the clear win would drop the interrupt. A tick that lands on the same cycle as a timer clear must keep the bit set; getting that wrong would lose a timer interrupt. Warning cases are mixed with fresh posts, so a design that rejects the whole request, or that forgets to warn, is caught, as is one that treats a bit-28-only write as an error or a zero vector as harmless. A response held under back-pressure is checked for stability, and a request offered during that hold must not be taken; a design that takes it would change the pending vector or lose a response.

// File: rtl/cih_pkg.sv
package cih_pkg;
  localparam int DATA_W = 32;
  localparam int MAX_CPU = 4;

  // control-register field positions (decoded by software, so they are fixed)
  localparam int CTL_REQ_LSB  = 12;
  localparam int CTL_CLR_LSB  = 8;
  localparam int CTL_TCLR_LSB = 4;
  localparam int CTL_NOP_BIT  = 28;
  localparam int CTL_RD_IPI   = 8;
  localparam int CTL_RD_TMR   = 4;

  typedef enum logic [1:0] {
    SEL_CTRL     = 2'd0,
    SEL_IPI_PEND = 2'd1,
    SEL_TMR_PEND = 2'd2,
    SEL_IPI_REQ  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [DATA_W-1:0] rdata;
    logic              err;
    logic              warn;
  } rsp_t;
endpackage

// File: rtl/cih_decode.sv
module cih_decode
  import cih_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic              write,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        cpu,
  input  logic [NCPU-1:0]   ipi_q,
  input  logic [NCPU-1:0]   tmr_q,
  output logic [NCPU-1:0]   ipi_set,
  output logic [NCPU-1:0]   ipi_clr,
  output logic [NCPU-1:0]   tmr_clr,
  output rsp_t              rsp
);
  logic [NCPU-1:0] vec;
  logic            ctl_any;
  logic            unused_bits;

  assign vec     = wdata[NCPU-1:0];
  assign ctl_any = (|wdata[15:4]) | wdata[CTL_NOP_BIT];
  assign unused_bits = ^{wdata[31:29], wdata[27:16]};

  always_comb begin
    ipi_set = '0;
    ipi_clr = '0;
    tmr_clr = '0;
    rsp     = '0;
    if (write) begin
      unique case (reg_sel_e'(addr))
        SEL_CTRL: begin
          if (!ctl_any) rsp.err = 1'b1;
          else begin
            ipi_set = wdata[CTL_REQ_LSB +: NCPU];
            ipi_clr = wdata[CTL_CLR_LSB +: NCPU];
            tmr_clr = wdata[CTL_TCLR_LSB +: NCPU];
          end
        end
        SEL_IPI_PEND: begin
          if (vec == '0) rsp.err = 1'b1;
          else ipi_clr = vec;
        end
        SEL_TMR_PEND: tmr_clr = vec;
        SEL_IPI_REQ: begin
          if (vec == '0) rsp.err = 1'b1;
          else ipi_set = vec;
        end
        default: rsp.err = 1'b1;
      endcase
      // clear is evaluated against the old vector, request against the cleared one
      rsp.warn = (|(ipi_set & ipi_q & ~ipi_clr)) | (|(ipi_clr & ~ipi_q));
    end else begin
      unique case (reg_sel_e'(addr))
        SEL_CTRL: begin
          rsp.rdata[CTL_RD_IPI +: NCPU] = ipi_q;
          rsp.rdata[CTL_RD_TMR +: NCPU] = tmr_q;
          rsp.rdata[1:0]                = cpu;
        end
        SEL_IPI_PEND: rsp.rdata[NCPU-1:0] = ipi_q;
        SEL_TMR_PEND: rsp.rdata[NCPU-1:0] = tmr_q;
        default:      rsp.rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cih_pending.sv
module cih_pending #(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] set,
  input  logic [NCPU-1:0] clr,
  output logic [NCPU-1:0] q
);
  for (genvar i = 0; i < NCPU; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]) else $error("set lost on bit %0d", i);
    p_clear_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !q[i]) else $error("clear lost on bit %0d", i);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[i] && !set[i]) |=> $stable(q[i])) else $error("bit %0d moved", i);
  end
endmodule

// File: rtl/cih_rsp_slot.sv
module cih_rsp_slot
  import cih_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  rsp_t din,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output rsp_t dout
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      dout      <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dout)))
    else $error("response changed under back-pressure");
  p_one_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid) else $error("missing response");
endmodule

// File: rtl/cpu_irq_hub.sv
module cpu_irq_hub
  import cih_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_cpu,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_warn,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   tmr_irq
);
  localparam int unsigned NC = (NCPU > MAX_CPU) ? MAX_CPU : NCPU;

  logic            accept;
  logic [NC-1:0]   d_set, d_clr, d_tclr;
  logic [NC-1:0]   ipi_q, tmr_q;
  rsp_t            d_rsp, q_rsp;

  assign accept = req_valid && req_ready;

  cih_decode #(.NCPU(NC)) u_dec (
    .write(req_write), .addr(req_addr), .wdata(req_wdata), .cpu(req_cpu),
    .ipi_q(ipi_q), .tmr_q(tmr_q),
    .ipi_set(d_set), .ipi_clr(d_clr), .tmr_clr(d_tclr), .rsp(d_rsp)
  );

  cih_pending #(.NCPU(NC)) u_ipi (
    .clk(clk), .rst_n(rst_n),
    .set(accept ? d_set : '0), .clr(accept ? d_clr : '0), .q(ipi_q)
  );

  cih_pending #(.NCPU(NC)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .set({NC{tick}}), .clr(accept ? d_tclr : '0), .q(tmr_q)
  );

  cih_rsp_slot u_rsp (
    .clk(clk), .rst_n(rst_n), .load(accept), .din(d_rsp),
    .out_ready(rsp_ready), .in_ready(req_ready), .out_valid(rsp_valid), .dout(q_rsp)
  );

  assign rsp_rdata = q_rsp.rdata;
  assign rsp_err   = q_rsp.err;
  assign rsp_warn  = q_rsp.warn;
  assign ipi_irq   = ipi_q;
  assign tmr_irq   = tmr_q;

  p_tick_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (&tmr_irq)) else $error("tick did not mark all processors");
  p_err_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && d_rsp.err) |=> $stable(ipi_irq)) else $error("error request changed IPI");
  p_no_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready) else $error("ready while response held");
endmodule

// File: tb/cpu_irq_hub_test.sv
module cpu_irq_hub_test;
  logic        clk = 0, rst_n = 0, tick = 0;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [1:0]  req_addr = 0, req_cpu = 0;
  logic [31:0] req_wdata = 0;
  logic        req_ready, rsp_valid, rsp_err, rsp_warn;
  logic [31:0] rsp_rdata;
  logic [3:0]  ipi_irq, tmr_irq;
  int checks = 0, errors = 0;
  logic        r_valid, r_err, r_warn;
  logic [31:0] r_data;

  always #4 clk = ~clk;

  cpu_irq_hub uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .rsp_warn(rsp_warn), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [1:0] a, input logic [31:0] d,
                      input logic [1:0] c, input logic tk);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_cpu = c; tick = tk;
    @(negedge clk);
    req_valid = 0; tick = 0;
    r_valid = rsp_valid; r_data = rsp_rdata; r_err = rsp_err; r_warn = rsp_warn;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic t_reset();
    chk("R12 ipi", {28'd0, ipi_irq}, 0);
    chk("R12 tmr", {28'd0, tmr_irq}, 0);
    chk("R12 rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R12 req_ready", {31'd0, req_ready}, 1);
  endtask

  task automatic t_post();
    xfer(1, 0, 32'h5000, 0, 0);
    chk("R11 rsp_valid", {31'd0, r_valid}, 1);
    chk("R1 ipi", {28'd0, ipi_irq}, 4'b0101);
    chk("R1 warn", {31'd0, r_warn}, 0);
  endtask

  task automatic t_redundant_post();
    xfer(1, 0, 32'h3000, 0, 0);
    chk("R3 ipi", {28'd0, ipi_irq}, 4'b0111);
    chk("R3 warn", {31'd0, r_warn}, 1);
    chk("R3 err", {31'd0, r_err}, 0);
  endtask

  task automatic t_clear();
    xfer(1, 0, 32'h0200, 0, 0);
    chk("R2 ipi clr", {28'd0, ipi_irq}, 4'b0101);
    chk("R2 warn", {31'd0, r_warn}, 0);
    xfer(1, 0, 32'h0A00, 0, 0);
    chk("R4 ipi", {28'd0, ipi_irq}, 4'b0101);
    chk("R4 warn", {31'd0, r_warn}, 1);
  endtask

  task automatic t_tick();
    pulse_tick();
    chk("R5 tick", {28'd0, tmr_irq}, 4'hF);
    xfer(1, 0, 32'h0030, 0, 0);
    chk("R2 tmr clr", {28'd0, tmr_irq}, 4'b1100);
    xfer(1, 2, 32'h000C, 0, 1);
    chk("R5 tick beats clear", {28'd0, tmr_irq}, 4'hF);
  endtask

  task automatic t_combined();
    xfer(1, 0, 32'h2200, 0, 0);
    chk("R6 ipi nonpending", {28'd0, ipi_irq}, 4'b0111);
    chk("R6 warn clr", {31'd0, r_warn}, 1);
    xfer(1, 0, 32'h1100, 0, 0);
    chk("R6 ipi pending", {28'd0, ipi_irq}, 4'b0111);
    chk("R6 no warn", {31'd0, r_warn}, 0);
  endtask

  task automatic t_dedicated();
    xfer(0, 1, 0, 0, 0);
    chk("R7 read ipi", r_data, 32'h7);
    xfer(1, 1, 32'h3, 0, 0);
    chk("R7 ipi clr", {28'd0, ipi_irq}, 4'b0100);
    xfer(1, 3, 32'h8, 0, 0);
    chk("R7 ipi req", {28'd0, ipi_irq}, 4'b1100);
    xfer(0, 3, 0, 0, 0);
    chk("R7 read req reg", r_data, 0);
    xfer(0, 2, 0, 0, 0);
    chk("R7 read tmr", r_data, 32'hF);
    xfer(1, 2, 32'hF, 0, 0);
    chk("R7 tmr clr", {28'd0, tmr_irq}, 0);
  endtask

  task automatic t_zero();
    xfer(1, 1, 0, 0, 0);
    chk("R8 err clr", {31'd0, r_err}, 1);
    chk("R8 ipi kept", {28'd0, ipi_irq}, 4'b1100);
    xfer(1, 3, 32'hFFF0, 0, 0);
    chk("R8 err req", {31'd0, r_err}, 1);
    chk("R8 ipi kept2", {28'd0, ipi_irq}, 4'b1100);
  endtask

  task automatic t_ctrl_unsup();
    xfer(1, 0, 32'h0000_000F, 0, 0);
    chk("R9 err", {31'd0, r_err}, 1);
    xfer(1, 0, 32'h1000_0000, 0, 0);
    chk("R9 bit28 ok", {31'd0, r_err}, 0);
    chk("R9 bit28 ipi", {28'd0, ipi_irq}, 4'b1100);
  endtask

  task automatic t_ctrl_read();
    pulse_tick();
    xfer(0, 0, 0, 2, 0);
    chk("R10 ctrl read", r_data, 32'h0000_0CF2);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = 1;
    @(negedge clk);
    chk("R11 valid", {31'd0, rsp_valid}, 1);
    chk("R11 ready low", {31'd0, req_ready}, 0);
    req_write = 1; req_addr = 3; req_wdata = 32'h1;
    @(negedge clk);
    req_valid = 0;
    chk("R11 held data", rsp_rdata, 32'hC);
    chk("R11 not taken", {28'd0, ipi_irq}, 4'b1100);
    rsp_ready = 1;
    @(negedge clk);
    chk("R11 drained", {31'd0, rsp_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_post();
    t_redundant_post();
    t_clear();
    t_tick();
    t_combined();
    t_dedicated();
    t_zero();
    t_ctrl_unsup();
    t_ctrl_read();
    t_backpressure();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule